// File: doc/BRIEF.md
# Diminished-one modulo 2^n+1 adder

This block adds two residues modulo 2^n+1 that are held in diminished-one code. A residue is carried as an n-bit field plus a one-bit zero flag: a nonzero residue v (1 to 2^n) has the flag low and the field set to v-1. The residue zero has the flag high, and its field is then meaningless. The datapath is purely combinational. It is meant to sit inside one channel of a residue-arithmetic pipeline, where the caller registers its inputs and outputs.

The implicit +1 of diminished-one addition is folded into a single carry network. The carry-out of the plain n-bit sum is inverted and injected back as the carry-in of every prefix position. A result whose true value is zero is detected when every bit position propagates and none generates. In that case the zero flag is raised and the field is cleared, so a field of 0 is never ambiguous. An operand whose zero flag is set bypasses the adder.

The carry network is chosen by parameter: a logarithmic-depth parallel prefix tree, or a serial chain with the same results.

Top module: `d1_modadd`

## Requirements
- R1: Code: zero flag value 1 means residue zero; zero flag 0 with field f means residue f+1. An output with the zero flag set always carries an all-zero field.
- R2: With both zero flags clear, the output encodes (x+y) mod (2^n+1), where x and y are the residues the operands encode.
- R3: With both flags clear and field_a+field_b >= 2^n, the output field is field_a+field_b-2^n and the output zero flag is 0.
- R4: With both flags clear and field_a+field_b < 2^n-1, the output field is field_a+field_b+1 and the output zero flag is 0.
- R5: With both flags clear and field_a+field_b = 2^n-1 (true sum 2^n+1), the output zero flag is 1 and the field is 0.
- R6: With only the first operand's zero flag set, the output equals the second operand's field with flag 0, whatever the first field holds.
- R7: With only the second operand's zero flag set, the output equals the first operand's field with flag 0, whatever the second field holds.
- R8: With both zero flags set, the output zero flag is 1 and the field is 0, whatever the fields hold.
- R9: The serial-carry variant (PFX = PFX_SERIAL) gives the same output as the prefix-tree variant for every input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_dim_i | input | WIDTH | First operand, diminished-one field |
| a_zero_i | input | 1 | First operand zero flag (1 = residue zero) |
| b_dim_i | input | WIDTH | Second operand, diminished-one field |
| b_zero_i | input | 1 | Second operand zero flag (1 = residue zero) |
| s_dim_o | output | WIDTH | Sum, diminished-one field |
| s_zero_o | output | 1 | Sum zero flag (1 = residue zero) |

## Verification
The block holds no state, so any internal fault appears at the ports in the same cycle as the operands that expose it. A wrong inverted carry shows up as an off-by-one field on one side of the 2^n boundary. A missing all-propagate detect shows up as a field of 0 with the flag low exactly where the true sum wraps to zero. A broken bypass shows up as a field leaking from a flagged operand. The sweep covers every residue pair for n = 4 and n = 8, with changing junk in flagged fields, so each of these faults is seen within one vector of its trigger.

// File: rtl/d1_modadd_pkg.sv
package d1_modadd_pkg;

  typedef enum logic {
    PFX_LOG    = 1'b0,
    PFX_SERIAL = 1'b1
  } pfx_e;

endpackage

// File: rtl/d1_prefix_carry.sv
// Group generate/propagate over bits [i:0] for every i.
module d1_prefix_carry
  import d1_modadd_pkg::*;
#(
  parameter int   W   = 8,
  parameter pfx_e PFX = PFX_LOG
) (
  input  logic [W-1:0] g_i,
  input  logic [W-1:0] p_i,
  output logic [W-1:0] gg_o,
  output logic [W-1:0] pp_o
);

  localparam int LVLS = $clog2(W);

  if (PFX == PFX_LOG) begin : g_tree
    for (genvar lv = 0; lv < LVLS; lv++) begin : lvl
      localparam int DIST = 1 << lv;
      logic [W-1:0] g_prev, p_prev, g_n, p_n;
      if (lv == 0) begin : g_base
        assign g_prev = g_i;
        assign p_prev = p_i;
      end else begin : g_link
        assign g_prev = lvl[lv-1].g_n;
        assign p_prev = lvl[lv-1].p_n;
      end
      for (genvar b = 0; b < W; b++) begin : bit_op
        if (b >= DIST) begin : g_comb
          assign g_n[b] = g_prev[b] | (p_prev[b] & g_prev[b-DIST]);
          assign p_n[b] = p_prev[b] & p_prev[b-DIST];
        end else begin : g_pass
          assign g_n[b] = g_prev[b];
          assign p_n[b] = p_prev[b];
        end
      end
    end
    assign gg_o = lvl[LVLS-1].g_n;
    assign pp_o = lvl[LVLS-1].p_n;
  end else begin : g_chain
    always_comb begin
      gg_o[0] = g_i[0];
      pp_o[0] = p_i[0];
      for (int i = 1; i < W; i++) begin
        gg_o[i] = g_i[i] | (p_i[i] & gg_o[i-1]);
        pp_o[i] = p_i[i] & pp_o[i-1];
      end
    end
  end

endmodule

// File: rtl/d1_eac_core.sv
// n-bit add with inverted end-around carry folded into the prefix carries.
module d1_eac_core
  import d1_modadd_pkg::*;
#(
  parameter int   W   = 8,
  parameter pfx_e PFX = PFX_LOG
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o,
  output logic         all_prop_o
);

  logic [W-1:0] g, p, gg, pp, cy;
  logic         cin;

  assign g = a_i & b_i;
  assign p = a_i ^ b_i;

  d1_prefix_carry #(.W(W), .PFX(PFX)) i_pfx (
    .g_i (g),
    .p_i (p),
    .gg_o(gg),
    .pp_o(pp)
  );

  // carry-out of the bare sum, inverted, is the +1
  assign cin = ~gg[W-1];

  assign cy[0] = cin;
  for (genvar i = 1; i < W; i++) begin : g_cy
    assign cy[i] = gg[i-1] | (pp[i-1] & cin);
  end

  assign sum_o      = p ^ cy;
  assign all_prop_o = pp[W-1];

endmodule

// File: rtl/d1_zero_sel.sv
// Zero-flag bypass and zero-result resolution.
module d1_zero_sel #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic         az_i,
  input  logic [W-1:0] b_i,
  input  logic         bz_i,
  input  logic [W-1:0] sum_i,
  input  logic         wrap_i,
  output logic [W-1:0] s_o,
  output logic         sz_o
);

  always_comb begin
    unique case ({az_i, bz_i})
      2'b11: begin s_o = '0;  sz_o = 1'b1; end
      2'b10: begin s_o = b_i; sz_o = 1'b0; end
      2'b01: begin s_o = a_i; sz_o = 1'b0; end
      default: begin
        if (wrap_i) begin
          s_o  = '0;
          sz_o = 1'b1;
        end else begin
          s_o  = sum_i;
          sz_o = 1'b0;
        end
      end
    endcase
  end

endmodule

// File: rtl/d1_modadd.sv
module d1_modadd
  import d1_modadd_pkg::*;
#(
  parameter int   WIDTH = 8,
  parameter pfx_e PFX   = PFX_LOG
) (
  input  logic [WIDTH-1:0] a_dim_i,
  input  logic             a_zero_i,
  input  logic [WIDTH-1:0] b_dim_i,
  input  logic             b_zero_i,
  output logic [WIDTH-1:0] s_dim_o,
  output logic             s_zero_o
);

  logic [WIDTH-1:0] core_sum;
  logic             core_wrap;

  d1_eac_core #(.W(WIDTH), .PFX(PFX)) i_core (
    .a_i       (a_dim_i),
    .b_i       (b_dim_i),
    .sum_o     (core_sum),
    .all_prop_o(core_wrap)
  );

  d1_zero_sel #(.W(WIDTH)) i_sel (
    .a_i   (a_dim_i),
    .az_i  (a_zero_i),
    .b_i   (b_dim_i),
    .bz_i  (b_zero_i),
    .sum_i (core_sum),
    .wrap_i(core_wrap),
    .s_o   (s_dim_o),
    .sz_o  (s_zero_o)
  );

endmodule

// File: rtl/d1_modadd_chk.sv
module d1_modadd_chk #(
  parameter int W = 8
) (
  input logic [W-1:0] a_dim_i,
  input logic         a_zero_i,
  input logic [W-1:0] b_dim_i,
  input logic         b_zero_i,
  input logic [W-1:0] s_dim_o,
  input logic         s_zero_o
);

  localparam logic [W:0] WRAP_PT = {1'b1, {W{1'b0}}};
  localparam logic [W:0] ALL_ONE = {1'b0, {W{1'b1}}};

  logic [W:0] raw;

  always_comb begin
    raw = {1'b0, a_dim_i} + {1'b0, b_dim_i};
    // R1
    zero_clean_chk: assert (!s_zero_o || s_dim_o == '0);
    // R3
    if (!a_zero_i && !b_zero_i && raw >= WRAP_PT)
      wrap_sum_chk: assert (!s_zero_o && s_dim_o == raw[W-1:0]);
    // R4
    if (!a_zero_i && !b_zero_i && raw < ALL_ONE)
      plus_one_chk: assert (!s_zero_o && s_dim_o == raw[W-1:0] + W'(1));
    // R5
    if (!a_zero_i && !b_zero_i && raw == ALL_ONE)
      zero_result_chk: assert (s_zero_o && s_dim_o == '0);
    // R6
    if (a_zero_i && !b_zero_i)
      pass_b_chk: assert (!s_zero_o && s_dim_o == b_dim_i);
    // R7
    if (!a_zero_i && b_zero_i)
      pass_a_chk: assert (!s_zero_o && s_dim_o == a_dim_i);
    // R8
    if (a_zero_i && b_zero_i)
      both_zero_chk: assert (s_zero_o && s_dim_o == '0);
  end

endmodule

bind d1_modadd d1_modadd_chk #(.W(WIDTH)) i_d1_modadd_chk (
  .a_dim_i (a_dim_i),
  .a_zero_i(a_zero_i),
  .b_dim_i (b_dim_i),
  .b_zero_i(b_zero_i),
  .s_dim_o (s_dim_o),
  .s_zero_o(s_zero_o)
);

// File: tb/test_d1_modadd.sv
module test_d1_modadd;
  import d1_modadd_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [3:0] a4, b4, s4;
  logic       az4, bz4, sz4;
  logic [7:0] a8, b8, s8, s8r;
  logic       az8, bz8, sz8, sz8r;

  d1_modadd #(.WIDTH(4)) i_d1_modadd_w4 (
    .a_dim_i(a4), .a_zero_i(az4), .b_dim_i(b4), .b_zero_i(bz4),
    .s_dim_o(s4), .s_zero_o(sz4)
  );

  d1_modadd #(.WIDTH(8)) i_d1_modadd (
    .a_dim_i(a8), .a_zero_i(az8), .b_dim_i(b8), .b_zero_i(bz8),
    .s_dim_o(s8), .s_zero_o(sz8)
  );

  d1_modadd #(.WIDTH(8), .PFX(PFX_SERIAL)) i_d1_modadd_ser (
    .a_dim_i(a8), .a_zero_i(az8), .b_dim_i(b8), .b_zero_i(bz8),
    .s_dim_o(s8r), .s_zero_o(sz8r)
  );

  task automatic chk(string req, int act_f, int act_z, int exp_f, int exp_z);
    total++;
    if (act_f != exp_f || act_z != exp_z) begin
      bad++;
      $display("FAIL %s: actual field=%0d zero=%0d expected field=%0d zero=%0d",
               req, act_f, act_z, exp_f, exp_z);
    end
  endtask

  function automatic string req_of(int x, int y, int n);
    int m = 1 << n;
    if (x == 0 && y == 0) return "R8";
    if (x == 0) return "R6";
    if (y == 0) return "R7";
    if (x + y == m + 1) return "R2/R5";
    if ((x - 1) + (y - 1) >= m) return "R2/R3";
    return "R2/R4";
  endfunction

  // residue x, junk used as field when x is zero
  task automatic drive4(int x, int y, int junk);
    az4 = (x == 0);
    bz4 = (y == 0);
    a4  = (x == 0) ? 4'(junk) : 4'(x - 1);
    b4  = (y == 0) ? 4'(junk >> 4) : 4'(y - 1);
  endtask

  task automatic drive8(int x, int y, int junk);
    az8 = (x == 0);
    bz8 = (y == 0);
    a8  = (x == 0) ? 8'(junk) : 8'(x - 1);
    b8  = (y == 0) ? 8'(junk * 7 + 3) : 8'(y - 1);
  endtask

  task automatic t_idle();
    @(posedge clk);
    drive4(0, 0, 0);
    drive8(0, 0, 0);
    @(negedge clk);
    chk("R1", int'(s4), int'(sz4), 0, 1);
    chk("R1", int'(s8), int'(sz8), 0, 1);
  endtask

  task automatic t_sweep4();
    for (int x = 0; x <= 16; x++) begin
      for (int y = 0; y <= 16; y++) begin
        int s;
        @(posedge clk);
        drive4(x, y, x * 17 + y * 5);
        @(negedge clk);
        s = (x + y) % 17;
        chk(req_of(x, y, 4), int'(s4), int'(sz4), (s == 0) ? 0 : s - 1, (s == 0) ? 1 : 0);
      end
    end
  endtask

  task automatic t_sweep8();
    for (int x = 0; x <= 256; x++) begin
      for (int y = 0; y <= 256; y++) begin
        int s;
        @(posedge clk);
        drive8(x, y, x ^ (y * 3));
        @(negedge clk);
        s = (x + y) % 257;
        chk(req_of(x, y, 8), int'(s8), int'(sz8), (s == 0) ? 0 : s - 1, (s == 0) ? 1 : 0);
        // R9 serial chain matches prefix tree
        chk("R9", int'(s8r), int'(sz8r), int'(s8), int'(sz8));
      end
    end
  endtask

  // R1 field 0 with flag low is residue one, distinct from zero
  task automatic t_one_vs_zero();
    @(posedge clk);
    drive8(1, 0, 8'hff);
    @(negedge clk);
    chk("R1", int'(s8), int'(sz8), 0, 0);
    @(posedge clk);
    drive8(256, 1, 0);
    @(negedge clk);
    chk("R5", int'(s8), int'(sz8), 0, 1);
    @(posedge clk);
    drive8(1, 1, 0);
    @(negedge clk);
    chk("R4", int'(s8), int'(sz8), 1, 0);
  endtask

  // flagged operand fields must not leak
  task automatic t_junk_fields();
    for (int j = 0; j < 256; j += 17) begin
      @(posedge clk);
      az8 = 1'b1; a8 = 8'(j); bz8 = 1'b0; b8 = 8'h5a;
      @(negedge clk);
      chk("R6", int'(s8), int'(sz8), 'h5a, 0);
      @(posedge clk);
      az8 = 1'b0; a8 = 8'h3c; bz8 = 1'b1; b8 = 8'(~j);
      @(negedge clk);
      chk("R7", int'(s8), int'(sz8), 'h3c, 0);
      @(posedge clk);
      az8 = 1'b1; a8 = 8'(j); bz8 = 1'b1; b8 = 8'(j + 1);
      @(negedge clk);
      chk("R8", int'(s8), int'(sz8), 0, 1);
    end
  endtask

  initial begin
    a4 = '0; b4 = '0; az4 = 1'b1; bz4 = 1'b1;
    a8 = '0; b8 = '0; az8 = 1'b1; bz8 = 1'b1;
    t_idle();
    t_one_vs_zero();
    t_junk_fields();
    t_sweep4();
    t_sweep8();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule